// File: doc/BRIEF.md
# Hundredths-Resolution Calendar Timekeeper

This block is the counting core of a real-time clock. A 100 Hz tick, made elsewhere from a 32.768 kHz time base, advances a chain of counters: hundredths, seconds, minutes, hours, day of month, weekday, month, two-digit year and a week number. Month lengths follow the calendar, and February gains a 29th day in leap years. All readable values are presented in BCD. The hour can be shown in 24-hour form or in 12-hour form with an AM/PM flag.

A sync control selects one of four behaviours. In the free-running mode the tick drives the chain. Two rounding modes snap the time to the nearest whole second or the nearest whole minute when a request pulse arrives. The line-locked mode ignores the tick and advances the hundredths by two on every rising edge of an external 50 Hz reference. A per-cycle skip input swallows a tick so that an outside trimming scheme can slow the rate. A register-load port writes one field per cycle.

The readable registers are a second bank. The whole bank is copied from the counters at one clock edge. A read therefore never sees a carry that is only partly applied.

Top module: `rtc_timekeeper`

## Requirements
- R1: In free-running mode (sync_mode 0), each cycle with tick_100hz high and tick_skip low advances the hundredths by one, counting 00 to 99. The step from 99 to 00 carries one into the seconds.
- R2: Seconds and minutes count 00 to 59 and hours count 00 to 23, each carrying into the next field. After 23:59:59.99 the next tick gives 00:00:00.00 and advances the day.
- R3: The day counts from 01 up to the length of the month: 30 for months 04, 06, 09 and 11, 31 for the other months except February, and 29 for February when the year is a multiple of 4 (otherwise 28). A day past the month end sets the day to 01 and advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R4: The weekday counts 1 to 7 and advances once per day, with 7 wrapping to 1.
- R5: The week number, 01 to 53, increases by one when the weekday wraps from 7 to 1 and stays at 53 once there. It is set to 01 when the year advances.
- R6: With fmt_12h low, rd_hour is the BCD hour 00 to 23. With fmt_12h high, bit 7 is 1 for hours 12 to 23 (PM), and bits 6:0 hold the BCD hour in the order 12, 01, ..., 11. Midnight reads 8'h12 and noon reads 8'h92.
- R7: A tick is ignored in any cycle where tick_skip is high.
- R8: With sync_mode 1, sync_req sets the hundredths to 00. If the hundredths were 50 or more, it also advances the seconds with full carry. The tick in that cycle is ignored.
- R9: With sync_mode 2, sync_req sets the hundredths and seconds to 00. If the seconds were 30 or more, it also advances the minutes with full carry. The tick in that cycle is ignored.
- R10: With sync_mode 3, tick_100hz and sync_req have no effect. Each cycle in which line_ref is high after being low in the previous cycle advances the hundredths by two, with carry.
- R11: load_en writes the BCD value on load_data into one field, chosen by load_sel: 0 hundredths, 1 seconds, 2 minutes, 3 hours (always in 24-hour form), 4 day, 5 weekday, 6 month, 7 year, 8 week. A load overrides any tick, line edge or sync request in the same cycle.
- R12: All readable registers change together, one cycle after the counters change. After reset they read hundredths 00, seconds 00, minutes 00, hour 00, day 01, weekday 01, month 01, year 00, week 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz |
| tick_skip | input | 1 | Drops the tick in the same cycle (rate trim) |
| fmt_12h | input | 1 | 1 selects 12-hour presentation of rd_hour |
| sync_mode | input | 2 | 0 free run, 1 round to second, 2 round to minute, 3 line lock |
| sync_req | input | 1 | Rounding request pulse |
| line_ref | input | 1 | 50 Hz reference used in line-lock mode |
| load_en | input | 1 | Writes one field this cycle |
| load_sel | input | 4 | Field selector for a load |
| load_data | input | 8 | BCD value for a load |
| rd_hund | output | 8 | Hundredths, BCD |
| rd_sec | output | 8 | Seconds, BCD |
| rd_min | output | 8 | Minutes, BCD |
| rd_hour | output | 8 | Hour, BCD, 12h or 24h form |
| rd_day | output | 8 | Day of month, BCD |
| rd_wday | output | 8 | Weekday 1 to 7, BCD |
| rd_month | output | 8 | Month, BCD |
| rd_year | output | 8 | Year 00 to 99, BCD |
| rd_week | output | 8 | Week number, BCD |

## Verification
Any stimulus changes the counters at the rising edge where it is sampled. The readable bank shows that change one edge later, formatted with the fmt_12h value sampled at that later edge. The reference model follows the same timing. After each rising edge it first forms the readable values from its state before the update, then applies the sampled inputs. It compares all nine outputs at the next falling edge, so latency, carries, rounding and precedence are all checked on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SYNC_OFF  = 2'd0,
    SYNC_SEC  = 2'd1,
    SYNC_MIN  = 2'd2,
    SYNC_LINE = 2'd3
  } sync_mode_e;

  typedef struct packed {
    logic [6:0] hund;
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [4:0] day;
    logic [2:0] wday;
    logic [3:0] month;
    logic [6:0] year;
    logic [5:0] week;
  } rtc_time_t;

  // binary (0..99) to two BCD digits
  function automatic logic [REG_W-1:0] to_bcd(input logic [6:0] v);
    logic [7:0] w;
    w = {1'b0, v};
    return ((w / 8'd10) << 4) | (w % 8'd10);
  endfunction

  function automatic logic [6:0] from_bcd(input logic [REG_W-1:0] b);
    return 7'({4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]});
  endfunction

  // year is binary 0..99, so a multiple of four has its low two bits clear
  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] hour_12(input logic [4:0] h);
    if (h == 5'd0)       return 8'h12;
    else if (h < 5'd12)  return to_bcd({2'd0, h});
    else if (h == 5'd12) return 8'h92;
    else                 return 8'h80 | to_bcd({2'd0, h - 5'd12});
  endfunction

endpackage

// File: rtl/rtc_sync_ctrl.sv
module rtc_sync_ctrl
  import rtc_pkg::*;
#(
  parameter int LINE_STEP = 2,
  parameter int STEP_W    = $clog2(LINE_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic              tick_skip,
  input  logic [1:0]        sync_mode,
  input  logic              sync_req,
  input  logic              line_ref,
  input  logic              load_en,
  output logic [STEP_W-1:0] step,
  output logic              round_sec,
  output logic              round_min,
  output logic              line_rise
);

  logic       line_q;
  sync_mode_e mode;

  assign mode      = sync_mode_e'(sync_mode);
  assign line_rise = line_ref & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_ref;
  end

  // priority: load, then rounding request, then the time step
  always_comb begin
    step      = '0;
    round_sec = 1'b0;
    round_min = 1'b0;
    if (!load_en) begin
      case (mode)
        SYNC_LINE: step = line_rise ? STEP_W'(LINE_STEP) : '0;
        SYNC_SEC:  if (sync_req) round_sec = 1'b1;
                   else          step = STEP_W'(tick_100hz & ~tick_skip);
        SYNC_MIN:  if (sync_req) round_min = 1'b1;
                   else          step = STEP_W'(tick_100hz & ~tick_skip);
        default:   step = STEP_W'(tick_100hz & ~tick_skip);
      endcase
    end
  end

endmodule

// File: rtl/rtc_counter_chain.sv
module rtc_counter_chain
  import rtc_pkg::*;
#(
  parameter int HUND_PER_SEC = 100,
  parameter int WEEK_LAST    = 53,
  parameter int STEP_W       = 2,
  parameter int SEL_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic              round_sec,
  input  logic              round_min,
  input  logic              load_en,
  input  logic [SEL_W-1:0]  load_sel,
  input  logic [REG_W-1:0]  load_data,
  output rtc_time_t         time_q,
  output logic              sec_up,
  output logic              min_up,
  output logic              hour_up,
  output logic              day_up,
  output logic              month_up,
  output logic              year_up,
  output logic              chain_active
);

  localparam logic [7:0] HUND_LIM = 8'(HUND_PER_SEC);
  localparam logic [5:0] WEEK_TOP = 6'(WEEK_LAST);

  rtc_time_t  nx;
  logic [7:0] hsum;
  logic [6:0] ld_bin;

  assign chain_active = load_en | round_sec | round_min | (step != '0);
  assign ld_bin       = from_bcd(load_data);

  always_comb begin
    nx       = time_q;
    sec_up   = 1'b0;
    min_up   = 1'b0;
    hour_up  = 1'b0;
    day_up   = 1'b0;
    month_up = 1'b0;
    year_up  = 1'b0;
    hsum     = {1'b0, time_q.hund} + 8'(step);

    if (round_min) begin
      nx.hund = '0;
      nx.sec  = '0;
      min_up  = (time_q.sec >= 6'd30);
    end else if (round_sec) begin
      nx.hund = '0;
      sec_up  = (time_q.hund >= 7'd50);
    end else if (step != '0) begin
      if (hsum >= HUND_LIM) begin
        nx.hund = 7'(hsum - HUND_LIM);
        sec_up  = 1'b1;
      end else begin
        nx.hund = hsum[6:0];
      end
    end

    if (sec_up) begin
      if (time_q.sec == 6'd59) begin nx.sec = '0; min_up = 1'b1; end
      else nx.sec = time_q.sec + 6'd1;
    end
    if (min_up) begin
      if (time_q.min == 6'd59) begin nx.min = '0; hour_up = 1'b1; end
      else nx.min = time_q.min + 6'd1;
    end
    if (hour_up) begin
      if (time_q.hour == 5'd23) begin nx.hour = '0; day_up = 1'b1; end
      else nx.hour = time_q.hour + 5'd1;
    end
    if (day_up) begin
      if (time_q.wday == 3'd7) begin
        nx.wday = 3'd1;
        nx.week = (time_q.week >= WEEK_TOP) ? WEEK_TOP : time_q.week + 6'd1;
      end else begin
        nx.wday = time_q.wday + 3'd1;
      end
      if (time_q.day >= month_len(time_q.month, time_q.year)) begin
        nx.day   = 5'd1;
        month_up = 1'b1;
      end else begin
        nx.day = time_q.day + 5'd1;
      end
    end
    if (month_up) begin
      if (time_q.month == 4'd12) begin nx.month = 4'd1; year_up = 1'b1; end
      else nx.month = time_q.month + 4'd1;
    end
    if (year_up) begin
      nx.year = (time_q.year == 7'd99) ? 7'd0 : time_q.year + 7'd1;
      nx.week = 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '{hund: '0, sec: '0, min: '0, hour: '0, day: 5'd1,
                  wday: 3'd1, month: 4'd1, year: '0, week: 6'd1};
    end else if (load_en) begin
      case (load_sel)
        SEL_W'(0): time_q.hund  <= ld_bin;
        SEL_W'(1): time_q.sec   <= 6'(ld_bin);
        SEL_W'(2): time_q.min   <= 6'(ld_bin);
        SEL_W'(3): time_q.hour  <= 5'(ld_bin);
        SEL_W'(4): time_q.day   <= 5'(ld_bin);
        SEL_W'(5): time_q.wday  <= 3'(ld_bin);
        SEL_W'(6): time_q.month <= 4'(ld_bin);
        SEL_W'(7): time_q.year  <= ld_bin;
        SEL_W'(8): time_q.week  <= 6'(ld_bin);
        default: ;
      endcase
    end else begin
      time_q <= nx;
    end
  end

endmodule

// File: rtl/rtc_view.sv
module rtc_view
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rtc_time_t        time_q,
  input  logic             fmt_12h,
  output logic [REG_W-1:0] rd_hund,
  output logic [REG_W-1:0] rd_sec,
  output logic [REG_W-1:0] rd_min,
  output logic [REG_W-1:0] rd_hour,
  output logic [REG_W-1:0] rd_day,
  output logic [REG_W-1:0] rd_wday,
  output logic [REG_W-1:0] rd_month,
  output logic [REG_W-1:0] rd_year,
  output logic [REG_W-1:0] rd_week
);

  // the chain settles within one cycle, so the whole bank is copied at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hund  <= 8'h00;
      rd_sec   <= 8'h00;
      rd_min   <= 8'h00;
      rd_hour  <= 8'h00;
      rd_day   <= 8'h01;
      rd_wday  <= 8'h01;
      rd_month <= 8'h01;
      rd_year  <= 8'h00;
      rd_week  <= 8'h01;
    end else begin
      rd_hund  <= to_bcd(time_q.hund);
      rd_sec   <= to_bcd({1'b0, time_q.sec});
      rd_min   <= to_bcd({1'b0, time_q.min});
      rd_hour  <= fmt_12h ? hour_12(time_q.hour) : to_bcd({2'd0, time_q.hour});
      rd_day   <= to_bcd({2'd0, time_q.day});
      rd_wday  <= to_bcd({4'd0, time_q.wday});
      rd_month <= to_bcd({3'd0, time_q.month});
      rd_year  <= to_bcd(time_q.year);
      rd_week  <= to_bcd({1'b0, time_q.week});
    end
  end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int HUND_PER_SEC = 100,
  parameter int LINE_STEP    = 2,
  parameter int WEEK_LAST    = 53,
  parameter int SEL_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_100hz,
  input  logic             tick_skip,
  input  logic             fmt_12h,
  input  logic [1:0]       sync_mode,
  input  logic             sync_req,
  input  logic             line_ref,
  input  logic             load_en,
  input  logic [SEL_W-1:0] load_sel,
  input  logic [7:0]       load_data,
  output logic [7:0]       rd_hund,
  output logic [7:0]       rd_sec,
  output logic [7:0]       rd_min,
  output logic [7:0]       rd_hour,
  output logic [7:0]       rd_day,
  output logic [7:0]       rd_wday,
  output logic [7:0]       rd_month,
  output logic [7:0]       rd_year,
  output logic [7:0]       rd_week
);

  localparam int STEP_W = $clog2(LINE_STEP + 1);

  logic [STEP_W-1:0] step;
  logic              round_sec, round_min, line_rise;
  logic              sec_up, min_up, hour_up, day_up, month_up, year_up;
  logic              chain_active;
  rtc_time_t         time_q;

  rtc_sync_ctrl #(.LINE_STEP(LINE_STEP), .STEP_W(STEP_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .tick_skip(tick_skip),
    .sync_mode(sync_mode), .sync_req(sync_req), .line_ref(line_ref),
    .load_en(load_en), .step(step), .round_sec(round_sec),
    .round_min(round_min), .line_rise(line_rise)
  );

  rtc_counter_chain #(
    .HUND_PER_SEC(HUND_PER_SEC), .WEEK_LAST(WEEK_LAST),
    .STEP_W(STEP_W), .SEL_W(SEL_W)
  ) u_chain (
    .clk(clk), .rst_n(rst_n), .step(step), .round_sec(round_sec),
    .round_min(round_min), .load_en(load_en), .load_sel(load_sel),
    .load_data(load_data), .time_q(time_q), .sec_up(sec_up),
    .min_up(min_up), .hour_up(hour_up), .day_up(day_up),
    .month_up(month_up), .year_up(year_up), .chain_active(chain_active)
  );

  rtc_view u_view (
    .clk(clk), .rst_n(rst_n), .time_q(time_q), .fmt_12h(fmt_12h),
    .rd_hund(rd_hund), .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour),
    .rd_day(rd_day), .rd_wday(rd_wday), .rd_month(rd_month),
    .rd_year(rd_year), .rd_week(rd_week)
  );

endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input rtc_time_t  time_q,
  input logic       load_en,
  input logic       round_sec,
  input logic       round_min,
  input logic       sec_up,
  input logic       day_up,
  input logic       chain_active,
  input logic       fmt_12h,
  input logic [7:0] rd_hund,
  input logic [7:0] rd_sec,
  input logic [7:0] rd_hour,
  input logic [7:0] rd_week
);

  assert_hund_bcd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hund[3:0] <= 4'd9) && (rd_hund[7:4] <= 4'd9));

  // a carry out of the hundredths leaves only the remainder of the step
  assert_hund_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_up && !round_sec && !load_en) |=> (time_q.hund <= 7'd1));

  assert_midnight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    day_up |=> (time_q.hour == 5'd0) && (time_q.min == 6'd0) && (time_q.sec == 6'd0));

  assert_leap_day_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q.month == 4'd2 && time_q.day == 5'd29) |-> (time_q.year[1:0] == 2'd0));

  assert_week_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_week != 8'h00) && (rd_week <= 8'h53));

  assert_hour12_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_12h |=> (rd_hour[6:0] != 7'h00) && (rd_hour[6:0] <= 7'h12));

  assert_round_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    round_sec |=> (time_q.hund == 7'd0));

  assert_round_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
    round_min |=> (time_q.hund == 7'd0) && (time_q.sec == 6'd0));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_active |=> $stable(time_q));

  assert_view_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_sec == to_bcd({1'b0, $past(time_q.sec)})));

endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .time_q(time_q), .load_en(load_en),
  .round_sec(round_sec), .round_min(round_min), .sec_up(sec_up),
  .day_up(day_up), .chain_active(chain_active), .fmt_12h(fmt_12h),
  .rd_hund(rd_hund), .rd_sec(rd_sec), .rd_hour(rd_hour), .rd_week(rd_week)
);

// File: tb/test_rtc_timekeeper.sv
`timescale 1ns/1ps
module test_rtc_timekeeper;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0, tick_skip = 1'b0, fmt_12h = 1'b0;
  logic [1:0] sync_mode = 2'd0;
  logic       sync_req = 1'b0, line_ref = 1'b0, load_en = 1'b0;
  logic [3:0] load_sel = 4'd0;
  logic [7:0] load_data = 8'd0;
  logic [7:0] rd_hund, rd_sec, rd_min, rd_hour, rd_day, rd_wday, rd_month, rd_year, rd_week;

  rtc_timekeeper i_rtc_timekeeper (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .tick_skip(tick_skip),
    .fmt_12h(fmt_12h), .sync_mode(sync_mode), .sync_req(sync_req),
    .line_ref(line_ref), .load_en(load_en), .load_sel(load_sel),
    .load_data(load_data), .rd_hund(rd_hund), .rd_sec(rd_sec), .rd_min(rd_min),
    .rd_hour(rd_hour), .rd_day(rd_day), .rd_wday(rd_wday), .rd_month(rd_month),
    .rd_year(rd_year), .rd_week(rd_week)
  );

  always #2.5 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;
  string tag = "R12";

  // reference state as plain integers
  int m_h = 0, m_s = 0, m_mi = 0, m_hr = 0, m_d = 1, m_wd = 1, m_mo = 1, m_y = 0, m_wk = 1;
  bit prev_line = 1'b0;
  logic [7:0] exp_v [9] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h01};
  string fname [9] = '{"hund", "sec", "min", "hour", "day", "wday", "month", "year", "week"};

  function automatic logic [7:0] b2(int x);
    return 8'(((x / 10) * 16) + (x % 10));
  endfunction

  function automatic int d2(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hr_view(int h, bit twelve);
    int hh;
    logic [7:0] v;
    if (!twelve) return b2(h);
    hh = h % 12;
    if (hh == 0) hh = 12;
    v = b2(hh);
    v[7] = (h >= 12);
    return v;
  endfunction

  task automatic bump_day();
    m_wd = m_wd + 1;
    if (m_wd > 7) begin
      m_wd = 1;
      if (m_wk < 53) m_wk++;
    end
    m_d++;
    if (m_d > days_in(m_mo, m_y)) begin
      m_d = 1;
      m_mo++;
      if (m_mo > 12) begin m_mo = 1; m_y = (m_y + 1) % 100; m_wk = 1; end
    end
  endtask

  task automatic bump_min();
    m_mi++;
    if (m_mi == 60) begin
      m_mi = 0;
      m_hr++;
      if (m_hr == 24) begin m_hr = 0; bump_day(); end
    end
  endtask

  task automatic bump_sec();
    m_s++;
    if (m_s == 60) begin m_s = 0; bump_min(); end
  endtask

  task automatic add_hund(int n);
    m_h += n;
    if (m_h >= 100) begin m_h -= 100; bump_sec(); end
  endtask

  // called just after a rising edge with the inputs sampled there
  task automatic model_edge();
    exp_v = '{b2(m_h), b2(m_s), b2(m_mi), hr_view(m_hr, fmt_12h), b2(m_d),
              b2(m_wd), b2(m_mo), b2(m_y), b2(m_wk)};
    if (load_en) begin
      case (load_sel)
        4'd0: m_h  = d2(load_data);
        4'd1: m_s  = d2(load_data);
        4'd2: m_mi = d2(load_data);
        4'd3: m_hr = d2(load_data);
        4'd4: m_d  = d2(load_data);
        4'd5: m_wd = d2(load_data);
        4'd6: m_mo = d2(load_data);
        4'd7: m_y  = d2(load_data);
        4'd8: m_wk = d2(load_data);
        default: ;
      endcase
    end else if (sync_mode == 2'd1 && sync_req) begin
      if (m_h >= 50) bump_sec();
      m_h = 0;
    end else if (sync_mode == 2'd2 && sync_req) begin
      m_h = 0;
      if (m_s >= 30) bump_min();
      m_s = 0;
    end else if (sync_mode == 2'd3) begin
      if (line_ref && !prev_line) add_hund(2);
    end else if (tick_100hz && !tick_skip) begin
      add_hund(1);
    end
    prev_line = line_ref;
  endtask

  task automatic compare();
    logic [7:0] act [9];
    act = '{rd_hund, rd_sec, rd_min, rd_hour, rd_day, rd_wday, rd_month, rd_year, rd_week};
    for (int k = 0; k < 9; k++) begin
      n_vec++;
      if (act[k] !== exp_v[k]) begin
        n_bad++;
        $display("FAIL %s %s actual=%h expected=%h at %0t", tag, fname[k], act[k], exp_v[k], $time);
      end
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic ld(int sel, logic [7:0] val);
    load_en = 1'b1; load_sel = 4'(sel); load_data = val;
    cyc();
    load_en = 1'b0;
  endtask

  task automatic set_time(logic [7:0] h, s, mi, hr, d, wd, mo, y, wk);
    ld(0, h); ld(1, s); ld(2, mi); ld(3, hr); ld(4, d);
    ld(5, wd); ld(6, mo); ld(7, y); ld(8, wk);
  endtask

  task automatic ticks(int n);
    tick_100hz = 1'b1;
    cyc(n);
    tick_100hz = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R12";
    compare();                                   // reset values of the readable bank

    tag = "R1";                                  // irregular tick pattern through carries
    for (int i = 0; i < 260; i++) begin
      tick_100hz = (i % 3 != 0);
      cyc();
    end
    tick_100hz = 1'b0;

    tag = "R7";                                  // skipped ticks leave the count unchanged
    for (int i = 0; i < 20; i++) begin
      tick_100hz = 1'b1; tick_skip = i[0];
      cyc();
    end
    tick_100hz = 1'b0; tick_skip = 1'b0;

    tag = "R2";
    set_time(8'h97, 8'h59, 8'h59, 8'h23, 8'h10, 8'h03, 8'h05, 8'h21, 8'h20);
    ticks(6);

    tag = "R3";                                  // common year February, leap February, 30-day month
    set_time(8'h98, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h03, 8'h09);
    ticks(4);
    set_time(8'h98, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h04, 8'h09);
    ticks(4);
    ld(1, 8'h59); ld(2, 8'h59); ld(3, 8'h23); ld(0, 8'h98);
    ticks(4);
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h04, 8'h50, 8'h17);
    ticks(3);
    set_time(8'h98, 8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99, 8'h52);
    ticks(4);

    tag = "R4";
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h11, 8'h06, 8'h03, 8'h07, 8'h10);
    ticks(3);

    tag = "R5";                                  // week increment and saturation at 53
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h11, 8'h07, 8'h03, 8'h07, 8'h52);
    ticks(3);
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h12, 8'h07, 8'h03, 8'h07, 8'h53);
    ticks(3);

    tag = "R6";                                  // midnight, morning, noon, afternoon, late evening
    fmt_12h = 1'b1;
    ld(3, 8'h00); cyc(2);
    ld(3, 8'h11); cyc(2);
    ld(3, 8'h12); cyc(2);
    ld(3, 8'h13); cyc(2);
    ld(3, 8'h23); cyc(2);
    set_time(8'h98, 8'h59, 8'h59, 8'h11, 8'h05, 8'h01, 8'h06, 8'h08, 8'h22);
    ticks(4);
    fmt_12h = 1'b0;
    cyc(2);

    tag = "R8";
    sync_mode = 2'd1;
    ld(0, 8'h49); sync_req = 1'b1; cyc(); sync_req = 1'b0; cyc(2);
    ld(0, 8'h50); sync_req = 1'b1; tick_100hz = 1'b1; cyc(); sync_req = 1'b0; cyc(2);
    tick_100hz = 1'b0;
    set_time(8'h73, 8'h59, 8'h59, 8'h23, 8'h31, 8'h07, 8'h12, 8'h99, 8'h53);
    sync_req = 1'b1; cyc(); sync_req = 1'b0; cyc(2);

    tag = "R9";
    sync_mode = 2'd2;
    ld(0, 8'h40); ld(1, 8'h29); sync_req = 1'b1; tick_100hz = 1'b1; cyc();
    sync_req = 1'b0; tick_100hz = 1'b0; cyc(2);
    ld(0, 8'h10); ld(1, 8'h30); ld(2, 8'h59); sync_req = 1'b1; cyc(); sync_req = 1'b0; cyc(2);

    tag = "R10";                                 // line lock: ticks and requests ignored
    sync_mode = 2'd3;
    ld(0, 8'h91);
    for (int i = 0; i < 120; i++) begin
      tick_100hz = 1'b1;
      sync_req = (i % 17 == 0);
      line_ref = ((i / 3) % 2 == 1);
      cyc();
    end
    tick_100hz = 1'b0; sync_req = 1'b0; line_ref = 1'b0;
    cyc(2);

    tag = "R11";                                 // load wins over tick, edge and request
    line_ref = 1'b1; load_en = 1'b1; load_sel = 4'd0; load_data = 8'h42;
    cyc(); load_en = 1'b0; line_ref = 1'b0; cyc(2);
    sync_mode = 2'd1; tick_100hz = 1'b1; sync_req = 1'b1;
    load_en = 1'b1; load_sel = 4'd1; load_data = 8'h17;
    cyc(); load_en = 1'b0; sync_req = 1'b0; tick_100hz = 1'b0; cyc(2);
    sync_mode = 2'd0;
    ld(2, 8'h33); ld(4, 8'h19); ld(7, 8'h45);
    cyc(2);

    tag = "R12";                                 // readable bank lags the counters by one edge
    ld(1, 8'h05); cyc(1);
    ticks(3);
    cyc(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule